// File: doc/BRIEF.md
# Banded Dynamic Time Warping Cost Engine

This block scores how well a candidate sequence matches a query sequence of the same length with the dynamic time warping measure. Both sequences are signed fixed-point samples. They are assumed to be normalized already, and they are written into two small local memories before a run starts. The accumulated cost matrix is filled one cell per clock, row by row. Only two rows are ever stored. Cells whose row and column indices lie further apart than a chosen radius are never computed and count as unreachable.

Each cell adds the squared sample difference to the smallest of its three neighbours (above, left and diagonal). Sums saturate at the largest representable value instead of wrapping. When a row is complete, its smallest cell is compared with a caller-supplied best-so-far limit. If every cell of the row is above that limit, the run stops early and flags that it gave up. Otherwise the final corner cell is returned as the distance.

Top module: `dtw_band_engine`

## Requirements
- R1: While the engine is idle, a write with `wr_en_i`=1 stores `wr_data_i` at index `wr_addr_i` of the query memory when `wr_sel_i`=0, or of the candidate memory when `wr_sel_i`=1. Index k holds sample k of the sequence.
- R2: After reset, `busy_o` and `done_o` are 0. When `start_i`=1 in an idle cycle, with `len_i` in 1..MAX_LEN, the engine captures `len_i`, `radius_i` and `threshold_i`, and `busy_o` is 1 from the next cycle on.
- R3: With d(i,j) = (q[i]-c[i... j])² written as (q[i]-c[j])², the engine forms D(0,0)=d(0,0) and D(i,j)=d(i,j)+min(D(i-1,j), D(i,j-1), D(i-1,j-1)). Indices outside the matrix read as the maximum value. On completion without abandon, `distance_o`=D(n-1,n-1).
- R4: A cell with |i-j| > `radius_i` counts as the maximum value and is never computed. A radius of at least n-1 gives unconstrained warping.
- R5: Accumulated costs saturate at 2^ACC_W-1. A predecessor at that value keeps the cell at that value.
- R6: After each row, including the last, if the smallest in-band cost of that row is strictly greater than `threshold_i`, the run ends with `abandoned_o`=1. A row minimum equal to the threshold does not abandon. A completed run reports `abandoned_o`=0.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle. `distance_o` and `abandoned_o` hold their values until the next run finishes.
- R8: While `busy_o`=1, `start_i` and memory writes are ignored. The run in progress and the stored samples are not changed by them.
- R9: Let C be the number of in-band cells in the rows processed, up to and including the row that ends the run. Count rising edges, starting with the edge that samples `start_i` as edge 1. `done_o` is high in the cycle after edge C+2. This is one initialization cycle plus one cycle per cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Sample write strobe |
| wr_sel_i | input | 1 | 0 selects query memory, 1 selects candidate memory |
| wr_addr_i | input | IDX_W | Sample index to write |
| wr_data_i | input | SAMP_W | Signed sample value |
| start_i | input | 1 | Begin a run |
| len_i | input | LEN_W | Sequence length n |
| radius_i | input | LEN_W | Band radius r |
| threshold_i | input | ACC_W | Best-so-far limit for early abandon |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abandoned_o | output | 1 | Last run stopped early |
| distance_o | output | ACC_W | Final accumulated cost |

## Verification
The bench builds the engine with MAX_LEN=8, 8-bit samples and an 18-bit accumulator. That configuration makes it cheap to sweep every length from 1 to 8 against every radius from 0 to 8. The sweep covers zero-width bands, partial bands and unconstrained warping. The narrow accumulator lets a handful of extreme-valued diagonal cells reach saturation. Identical sequences give row minima of exactly zero, so a zero threshold probes the equality boundary of the abandon test. A nonzero threshold makes runs stop at different rows, which exercises the cycle count of partial runs.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_RUN
    } dtw_state_e;

    // first column of the band for a row
    function automatic int band_lo(input int row, input int rad);
        return (row > rad) ? row - rad : 0;
    endfunction

    // last column of the band for a row
    function automatic int band_hi(input int row, input int rad, input int len);
        return (row + rad < len - 1) ? row + rad : len - 1;
    endfunction

endpackage

// File: rtl/dtw_vec_mem.sv
module dtw_vec_mem #(
    parameter int SAMP_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_addr,
    input  logic signed [SAMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_addr,
    output logic signed [SAMP_W-1:0] rd_data
);
    logic signed [SAMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dtw_row_buf.sv
module dtw_row_buf #(
    parameter int ACC_W = 24,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             swap,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [ACC_W-1:0] rd_data_a,
    output logic [ACC_W-1:0] rd_data_b
);
    localparam logic [ACC_W-1:0] SAT = '1;

    logic [ACC_W-1:0] rows [2][DEPTH];
    logic             cur_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_q <= 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                rows[0][k] <= SAT;
                rows[1][k] <= SAT;
            end
        end else begin
            if (wr_en) rows[cur_q][wr_idx] <= wr_data;
            if (swap)  cur_q <= ~cur_q;
        end
    end

    assign rd_data_a = rows[~cur_q][rd_idx_a];
    assign rd_data_b = rows[~cur_q][rd_idx_b];

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < DEPTH));

endmodule

// File: rtl/dtw_cell.sv
module dtw_cell #(
    parameter int SAMP_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic signed [SAMP_W-1:0] q_i,
    input  logic signed [SAMP_W-1:0] c_i,
    input  logic [ACC_W-1:0]         up_i,
    input  logic [ACC_W-1:0]         left_i,
    input  logic [ACC_W-1:0]         diag_i,
    input  logic                     origin_i,
    output logic [ACC_W-1:0]         cost_o
);
    localparam int SQ_W  = 2 * (SAMP_W + 1);
    localparam int SUM_W = ((ACC_W > SQ_W) ? ACC_W : SQ_W) + 1;
    localparam logic [ACC_W-1:0] SAT = '1;

    logic signed [SAMP_W:0] diff;
    logic [SAMP_W:0]        mag;
    logic [SQ_W-1:0]        sq;
    logic [ACC_W-1:0]       min_pred;
    logic [ACC_W-1:0]       base;
    logic [SUM_W-1:0]       sum;

    always_comb begin
        diff = $signed({q_i[SAMP_W-1], q_i}) - $signed({c_i[SAMP_W-1], c_i});
        mag  = diff[SAMP_W] ? -diff : diff;
        sq   = SQ_W'(mag) * SQ_W'(mag);
        min_pred = (up_i < left_i) ? up_i : left_i;
        if (diag_i < min_pred) min_pred = diag_i;
        base = origin_i ? '0 : min_pred;
        sum  = SUM_W'(sq) + SUM_W'(base);
        if ((!origin_i && min_pred == SAT) || sum > SUM_W'(SAT))
            cost_o = SAT;
        else
            cost_o = sum[ACC_W-1:0];
    end

    always_comb begin
        if (!origin_i) begin
            assert_cost_floor_R5: assert (cost_o >= min_pred);
        end
    end

endmodule

// File: rtl/dtw_band_engine.sv
module dtw_band_engine
    import dtw_pkg::*;
#(
    parameter int SAMP_W  = 8,
    parameter int ACC_W   = 24,
    parameter int MAX_LEN = 32,
    localparam int IDX_W  = $clog2(MAX_LEN),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic                     wr_sel_i,
    input  logic [IDX_W-1:0]         wr_addr_i,
    input  logic signed [SAMP_W-1:0] wr_data_i,
    input  logic                     start_i,
    input  logic [LEN_W-1:0]         len_i,
    input  logic [LEN_W-1:0]         radius_i,
    input  logic [ACC_W-1:0]         threshold_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     abandoned_o,
    output logic [ACC_W-1:0]         distance_o
);
    localparam logic [ACC_W-1:0] SAT = '1;

    dtw_state_e        state_q;
    logic [IDX_W-1:0]  i_q, j_q;
    logic [LEN_W-1:0]  n_q, r_q;
    logic [ACC_W-1:0]  thr_q, left_q, rowmin_q, dist_q;
    logic              done_q, aband_q;

    int i_int, j_int, n_int, r_int, lo_cur, hi_cur, lo_next;
    logic up_ok, diag_ok, left_ok, origin, last_in_row, idle, len_ok;
    logic signed [SAMP_W-1:0] q_samp, c_samp;
    logic [ACC_W-1:0] prev_up, prev_diag, up_v, left_v, diag_v, cost, rowmin_nx;
    logic [IDX_W-1:0] diag_idx;

    always_comb begin
        i_int   = int'(i_q);
        j_int   = int'(j_q);
        n_int   = int'(n_q);
        r_int   = int'(r_q);
        lo_cur  = band_lo(i_int, r_int);
        hi_cur  = band_hi(i_int, r_int, n_int);
        lo_next = band_lo(i_int + 1, r_int);
        idle    = (state_q == ST_IDLE);
        len_ok  = (len_i != '0) && (int'(len_i) <= MAX_LEN);
        up_ok   = (i_int > 0) && (j_int <= i_int - 1 + r_int) && (i_int - 1 <= j_int + r_int);
        diag_ok = (i_int > 0) && (j_int > 0);
        left_ok = (j_int > lo_cur);
        origin  = (i_int == 0) && (j_int == 0);
        diag_idx = diag_ok ? j_q - IDX_W'(1) : '0;
        up_v    = up_ok   ? prev_up   : SAT;
        diag_v  = diag_ok ? prev_diag : SAT;
        left_v  = left_ok ? left_q    : SAT;
        last_in_row = (j_int == hi_cur);
        rowmin_nx = (j_int == lo_cur) ? cost : ((cost < rowmin_q) ? cost : rowmin_q);
    end

    dtw_vec_mem #(.SAMP_W(SAMP_W), .DEPTH(MAX_LEN)) u_qmem (
        .clk(clk), .wr_en(wr_en_i && !wr_sel_i && idle), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .rd_addr(i_q), .rd_data(q_samp));

    dtw_vec_mem #(.SAMP_W(SAMP_W), .DEPTH(MAX_LEN)) u_cmem (
        .clk(clk), .wr_en(wr_en_i && wr_sel_i && idle), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .rd_addr(j_q), .rd_data(c_samp));

    dtw_row_buf #(.ACC_W(ACC_W), .DEPTH(MAX_LEN)) u_rows (
        .clk(clk), .rst(rst), .clr(state_q == ST_INIT),
        .wr_en(state_q == ST_RUN), .wr_idx(j_q), .wr_data(cost),
        .swap((state_q == ST_RUN) && last_in_row),
        .rd_idx_a(j_q), .rd_idx_b(diag_idx),
        .rd_data_a(prev_up), .rd_data_b(prev_diag));

    dtw_cell #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_cell (
        .q_i(q_samp), .c_i(c_samp), .up_i(up_v), .left_i(left_v),
        .diag_i(diag_v), .origin_i(origin), .cost_o(cost));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            i_q      <= '0;
            j_q      <= '0;
            n_q      <= '0;
            r_q      <= '0;
            thr_q    <= '0;
            left_q   <= SAT;
            rowmin_q <= SAT;
            dist_q   <= '0;
            done_q   <= 1'b0;
            aband_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i && len_ok) begin
                    n_q     <= len_i;
                    r_q     <= radius_i;
                    thr_q   <= threshold_i;
                    i_q     <= '0;
                    j_q     <= '0;
                    state_q <= ST_INIT;
                end
                ST_INIT: state_q <= ST_RUN;
                ST_RUN: begin
                    left_q   <= cost;
                    rowmin_q <= rowmin_nx;
                    if (last_in_row) begin
                        if (rowmin_nx > thr_q) begin
                            done_q  <= 1'b1;
                            aband_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (i_int == n_int - 1) begin
                            done_q  <= 1'b1;
                            aband_q <= 1'b0;
                            dist_q  <= cost;
                            state_q <= ST_IDLE;
                        end else begin
                            i_q <= i_q + IDX_W'(1);
                            j_q <= IDX_W'(lo_next);
                        end
                    end else begin
                        j_q <= j_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = !idle;
    assign done_o      = done_q;
    assign abandoned_o = aband_q;
    assign distance_o  = dist_q;

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && start_i && len_ok) |=> busy_o);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(state_q) == ST_IDLE) |-> ($stable(distance_o) && $stable(abandoned_o)));
    assert_cell_in_band_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (j_int >= lo_cur && j_int <= hi_cur && i_int < n_int));

endmodule

// File: tb/sim_dtw_band_engine.sv
`timescale 1ns/1ps
module sim_dtw_band_engine;
    localparam int SAMP_W = 8;
    localparam int ACC_W  = 18;
    localparam int ML     = 8;
    localparam int IDX_W  = $clog2(ML);
    localparam int LEN_W  = $clog2(ML + 1);
    localparam longint MAXV = (longint'(1) << ACC_W) - 1;

    logic clk = 0, rst = 1;
    logic wr_en = 0, wr_sel = 0, start = 0;
    logic [IDX_W-1:0] wr_addr = '0;
    logic signed [SAMP_W-1:0] wr_data = '0;
    logic [LEN_W-1:0] len = '0, radius = '0;
    logic [ACC_W-1:0] threshold = '0;
    logic busy, done, abandoned;
    logic [ACC_W-1:0] distance;

    int checks = 0, errors = 0;
    int qs[ML], cs[ML];
    longint exp_dist;
    int exp_ab, exp_cells;
    longint obs_dist;
    int obs_ab, obs_cnt, obs_tail_ok;

    always #2.5 clk = ~clk;

    dtw_band_engine #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .MAX_LEN(ML)) u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .start_i(start), .len_i(len), .radius_i(radius),
        .threshold_i(threshold), .busy_o(busy), .done_o(done),
        .abandoned_o(abandoned), .distance_o(distance));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int qval(input int pat, input int k);
        case (pat)
            0: return (k * 37) % 101 - 50;
            1: return (k % 2) ? 127 : -128;
            default: return k * 20 - 70;
        endcase
    endfunction

    function automatic int cval(input int pat, input int k);
        case (pat)
            0: return (k * 53 + 17) % 97 - 48;
            1: return (k % 2) ? -128 : 127;
            default: return k * 20 - 70;
        endcase
    endfunction

    // R1: write both memories at index k with sample k
    task automatic load(input int pat);
        for (int k = 0; k < ML; k++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                wr_en = 1; wr_sel = s[0]; wr_addr = IDX_W'(k);
                wr_data = SAMP_W'(s == 0 ? qval(pat, k) : cval(pat, k));
            end
            qs[k] = qval(pat, k);
            cs[k] = cval(pat, k);
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic model(input int n, input int r, input longint thr);
        longint dm[ML][ML];
        longint up, lf, dg, mn, d, rmin;
        exp_ab = 0; exp_cells = 0; exp_dist = 0;
        for (int i = 0; i < n; i++) begin
            rmin = MAXV;
            for (int j = 0; j < n; j++) begin
                d = longint'(qs[i] - cs[j]) * longint'(qs[i] - cs[j]);
                if ((i - j > r) || (j - i > r)) begin
                    dm[i][j] = MAXV;
                end else begin
                    exp_cells++;
                    if (i == 0 && j == 0) begin
                        mn = 0;
                    end else begin
                        up = (i > 0) ? dm[i-1][j] : MAXV;
                        lf = (j > 0) ? dm[i][j-1] : MAXV;
                        dg = (i > 0 && j > 0) ? dm[i-1][j-1] : MAXV;
                        mn = (up < lf) ? up : lf;
                        if (dg < mn) mn = dg;
                    end
                    dm[i][j] = (mn == MAXV || d + mn > MAXV) ? MAXV : d + mn;
                    if (dm[i][j] < rmin) rmin = dm[i][j];
                end
            end
            if (rmin > thr) begin
                exp_ab = 1;
                return;
            end
        end
        exp_dist = dm[n-1][n-1];
    endtask

    task automatic run(input int n, input int r, input longint thr, input bit inject);
        int cnt;
        bit seen;
        @(negedge clk);
        start = 1; len = LEN_W'(n); radius = LEN_W'(r); threshold = ACC_W'(thr);
        cnt = 0; seen = 0;
        while (!seen && cnt < 1000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start = 0; wr_en = 0;
            if (inject && cnt == 3) begin
                start = 1; len = LEN_W'(1); radius = '0; threshold = '0;
                wr_en = 1; wr_sel = 0; wr_addr = '0; wr_data = 8'sd99;
            end
            if (done) seen = 1;
        end
        start = 0; wr_en = 0;
        obs_cnt = seen ? cnt : -1;
        obs_dist = longint'(distance);
        obs_ab = int'(abandoned);
        @(negedge clk);
        obs_tail_ok = (!done && !busy) ? 1 : 0;
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        longint thr_set[3];
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !done, "R2", "idle after reset", {busy, done}, 0);

        thr_set[0] = MAXV; thr_set[1] = 0; thr_set[2] = 1500;
        for (int pat = 0; pat < 3; pat++) begin
            load(pat);
            for (int n = 1; n <= ML; n++) begin
                for (int r = 0; r <= ML; r++) begin
                    for (int t = 0; t < 3; t++) begin
                        model(n, r, thr_set[t]);
                        run(n, r, thr_set[t], 0);
                        check(obs_cnt == exp_cells + 2, "R9", "cycles to done", obs_cnt, exp_cells + 2);
                        check(obs_ab == exp_ab, "R6", "abandon flag", obs_ab, exp_ab);
                        if (exp_ab == 0) begin
                            if (exp_dist == MAXV)     tag = "R5";
                            else if (r < n - 1)       tag = "R4";
                            else if (pat == 2)        tag = "R1";
                            else                      tag = "R3";
                            check(obs_dist == exp_dist, tag, "distance", obs_dist, exp_dist);
                        end
                        check(obs_tail_ok == 1, "R7", "done single pulse, busy low", obs_tail_ok, 1);
                    end
                end
            end
        end

        // R8: start and writes during a run are ignored
        load(0);
        model(ML, 2, MAXV);
        run(ML, 2, MAXV, 1);
        check(obs_cnt == exp_cells + 2, "R8", "cycles with stray start", obs_cnt, exp_cells + 2);
        check(obs_dist == exp_dist, "R8", "distance with stray start", obs_dist, exp_dist);
        run(ML, 2, MAXV, 0);
        check(obs_dist == exp_dist, "R8", "memory unchanged by busy write", obs_dist, exp_dist);

        // R7: result held while idle
        repeat (6) @(negedge clk);
        check(longint'(distance) == exp_dist && !abandoned, "R7", "result held",
              longint'(distance), exp_dist);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule